// File: doc/BRIEF.md
# Direct Segment Address Translator

This block translates data virtual addresses next to a conventional page-based translation path. It does not sit on top of that path. Each process owns three registers: a window start, a window end and a displacement. Together they describe one contiguous virtual range that maps linearly onto contiguous physical memory. A request whose address lies inside the window gets its physical address from a single subtraction. For such a request, the result of the paging path and its miss indication are discarded, so no page walk is launched. Every other request is served by the paging path, and this block passes that path's result through unchanged.

The range check runs in the same cycle that the lookup request is presented to the TLB. The paging path's answer (hit flag and physical address) arrives alongside the request. The chosen result is registered into a one-entry output stage that uses a valid/ready handshake. Each response carries a source flag that tells a segment translation apart from a paged one.

Software saves and restores the three registers through a small register port on every context switch. A saturating counter records how many segment translations covered a request that the TLB would have missed, and software can read and clear it through the same port. The incoming `rst_n` is asynchronous when asserted and must be released synchronously to `clk` by the surrounding logic.

Top module: `dseg_xlate`

## Requirements
- R1: While reset is asserted and right after it, `rsp_valid` is 0, `req_ready` is 1, and all four register-port locations read 0.
- R2: An accepted request with `win_start <= req_va < win_end` (unsigned) is a segment hit. Its response has `rsp_pa = req_va - win_disp` (modulo 2^PA_W) and `rsp_src = 1`.
- R3: An accepted request that is not a segment hit produces a response with `rsp_pa = tlb_pa`, `rsp_src = 0` and `rsp_miss = !tlb_hit`.
- R4: The window start address itself is inside the window. The window end address is outside it, so the end is exclusive.
- R5: When the window start equals the window end, the segment is off and every request takes the paging result.
- R6: `walk_req` is 1 in the cycle a request is accepted only when the request is not a segment hit and `tlb_hit` is 0. A segment-hit response always has `rsp_miss = 0`.
- R7: A register write takes effect on the next clock edge. A request accepted in the same cycle as the write is translated with the old values.
- R8: Register port locations, selected by `cfg_addr`: 0 holds the window start, 1 holds the window end, 2 holds the displacement, 3 holds the counter (zero-extended). `cfg_rdata` shows the selected location in the same cycle.
- R9: The counter increases by one for each accepted segment hit with `tlb_hit = 0`. It stops at 2^CNT_W-1. A write to location 3 clears it, whatever the data, and the clear wins over an increment in the same cycle.
- R10: `req_ready = !rsp_valid || rsp_ready`. While `rsp_valid = 1` and `rsp_ready = 0`, the response and its flags hold steady.
- R11: A request accepted at a clock edge has its response on the outputs (`rsp_valid = 1`) from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | 2 | Register port location select |
| cfg_wdata | input | VA_W | Register port write data |
| cfg_rdata | output | VA_W | Register port read data (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | VA_W | Virtual address to translate |
| tlb_hit | input | 1 | Paging path hit for this request |
| tlb_pa | input | PA_W | Paging path physical address |
| walk_req | output | 1 | Page walk launch for the accepted request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_src | output | 1 | 1 = segment translation, 0 = paging |
| rsp_miss | output | 1 | Paging path missed for this response |

## Verification
`walk_req` and `cfg_rdata` are combinational, so the bench checks them at the falling edge of the same cycle the stimulus is applied. A response is due at the falling edge right after the rising edge that accepted its request. The driver checks `rsp_valid` there, and the monitor pops its expected item from the scoreboard queue at any falling edge where `rsp_valid` and `rsp_ready` are both high. Register writes and counter updates become visible one edge after the strobe, so read-back checks are made at the falling edge that follows. Stimulus changes shortly after each rising edge, and every check samples at a falling edge.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

  // Register port location map
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_DISP  = 2'd2,
    SEL_COUNT = 2'd3
  } dseg_sel_e;

  // Response source flag
  typedef enum logic {
    SRC_PAGE = 1'b0,
    SRC_SEG  = 1'b1
  } dseg_src_e;

endpackage

// File: rtl/dseg_regs.sv
module dseg_regs
  import dseg_pkg::*;
#(
  parameter int VA_W  = 47,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [VA_W-1:0]  cfg_wdata,
  output logic [VA_W-1:0]  cfg_rdata,
  input  logic             cnt_inc,
  output logic [VA_W-1:0]  win_start,
  output logic [VA_W-1:0]  win_end,
  output logic [VA_W-1:0]  win_disp
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  dseg_sel_e        sel;
  logic [VA_W-1:0]  start_q, end_q, disp_q;
  logic [VA_W-1:0]  start_d, end_d, disp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_en, end_en, disp_en, cnt_en, cnt_clr;

  // Next-state logic
  always_comb begin
    sel      = dseg_sel_e'(cfg_addr);
    start_en = cfg_we && (sel == SEL_START);
    end_en   = cfg_we && (sel == SEL_END);
    disp_en  = cfg_we && (sel == SEL_DISP);
    cnt_clr  = cfg_we && (sel == SEL_COUNT);
    start_d  = cfg_wdata;
    end_d    = cfg_wdata;
    disp_d   = cfg_wdata;
    cnt_en   = cnt_clr || (cnt_inc && (cnt_q != CNT_MAX));
    cnt_d    = cnt_clr ? '0 : (cnt_q + 1'b1);
  end

  // State registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      disp_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (end_en)   end_q   <= end_d;
      if (disp_en)  disp_q  <= disp_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_START: cfg_rdata = start_q;
      SEL_END:   cfg_rdata = end_q;
      SEL_DISP:  cfg_rdata = disp_q;
      default:   cfg_rdata = VA_W'(cnt_q);
    endcase
  end

  assign win_start = start_q;
  assign win_end   = end_q;
  assign win_disp  = disp_q;

  // Saturation: a full counter without a clear stays full
  assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !cnt_clr) |=> (cnt_q == CNT_MAX));

  // Counter never jumps by more than one without a clear
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && cnt_q != CNT_MAX) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // A window-end write shows up at the following edge
  assert_wr_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd1) |=> (end_q == $past(cfg_wdata)));

endmodule

// File: rtl/dseg_range.sv
module dseg_range #(
  parameter int VA_W = 47,
  parameter int PA_W = 47
) (
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] win_start,
  input  logic [VA_W-1:0] win_end,
  input  logic [VA_W-1:0] win_disp,
  output logic            seg_hit,
  output logic [PA_W-1:0] seg_pa
);

  logic            above_start;
  logic            below_end;
  logic [VA_W-1:0] diff;

  always_comb begin
    above_start = (va >= win_start);
    below_end   = (va < win_end);   // end is exclusive
    seg_hit     = above_start && below_end;
    diff        = va - win_disp;
  end

  generate
    if (PA_W == VA_W) begin : g_full
      assign seg_pa = diff;
    end else begin : g_trunc
      assign seg_pa = diff[PA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/dseg_rsp.sv
module dseg_rsp #(
  parameter int PA_W = 47
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_fire,
  input  logic [PA_W-1:0] in_pa,
  input  logic            in_src,
  input  logic            in_miss,
  output logic            in_ready,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_src,
  output logic            rsp_miss
);

  logic            valid_q, valid_d;
  logic [PA_W-1:0] pa_q;
  logic            src_q, miss_q;
  logic            load_en;

  always_comb begin
    in_ready = !valid_q || rsp_ready;
    load_en  = in_fire;
    if (in_fire)        valid_d = 1'b1;
    else if (rsp_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pa_q    <= '0;
      src_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        pa_q   <= in_pa;
        src_q  <= in_src;
        miss_q <= in_miss;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_pa    = pa_q;
  assign rsp_src   = src_q;
  assign rsp_miss  = miss_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_src) && $stable(rsp_miss)));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> rsp_valid);

  assert_seg_nomiss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src) |-> !rsp_miss);

endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
  import dseg_pkg::*;
#(
  parameter int VA_W  = 47,
  parameter int PA_W  = 47,
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [VA_W-1:0] cfg_wdata,
  output logic [VA_W-1:0] cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            tlb_hit,
  input  logic [PA_W-1:0] tlb_pa,
  output logic            walk_req,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_src,
  output logic            rsp_miss
);

  logic [VA_W-1:0] win_start, win_end, win_disp;
  logic            seg_hit;
  logic [PA_W-1:0] seg_pa;
  logic            fire;
  logic            cnt_inc;
  logic [PA_W-1:0] sel_pa;
  dseg_src_e       sel_src;
  logic            sel_miss;

  dseg_regs #(.VA_W(VA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cnt_inc   (cnt_inc),
    .win_start (win_start),
    .win_end   (win_end),
    .win_disp  (win_disp)
  );

  dseg_range #(.VA_W(VA_W), .PA_W(PA_W)) u_range (
    .va        (req_va),
    .win_start (win_start),
    .win_end   (win_end),
    .win_disp  (win_disp),
    .seg_hit   (seg_hit),
    .seg_pa    (seg_pa)
  );

  // Result selection: a segment hit overrides the paging answer
  always_comb begin
    fire     = req_valid && req_ready;
    sel_pa   = seg_hit ? seg_pa : tlb_pa;
    sel_src  = seg_hit ? SRC_SEG : SRC_PAGE;
    sel_miss = !seg_hit && !tlb_hit;
    walk_req = fire && sel_miss;
    cnt_inc  = fire && seg_hit && !tlb_hit;
  end

  dseg_rsp #(.PA_W(PA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (fire),
    .in_pa     (sel_pa),
    .in_src    (sel_src),
    .in_miss   (sel_miss),
    .in_ready  (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_pa    (rsp_pa),
    .rsp_src   (rsp_src),
    .rsp_miss  (rsp_miss)
  );

  // An empty window never claims a request
  assert_off_when_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_start == win_end) |-> !seg_hit);

  // The exclusive end address is never claimed
  assert_end_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_va == win_end) |-> !seg_hit);

endmodule

// File: tb/dseg_xlate_bench.sv
`timescale 1ns/1ps
module dseg_xlate_bench;

  localparam int VA_W  = 47;
  localparam int PA_W  = 47;
  localparam int CNT_W = 3;
  localparam int CMAX  = 7;

  typedef struct packed {
    logic [PA_W-1:0] pa;
    logic            src;
    logic            miss;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_addr = '0;
  logic [VA_W-1:0] cfg_wdata = '0;
  logic [VA_W-1:0] cfg_rdata;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [VA_W-1:0] req_va = '0;
  logic            tlb_hit = 1'b0;
  logic [PA_W-1:0] tlb_pa = '0;
  logic            walk_req;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [PA_W-1:0] rsp_pa;
  logic            rsp_src;
  logic            rsp_miss;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  // Bench model of the per-process registers
  logic [VA_W-1:0] m_start = '0, m_end = '0, m_disp = '0;
  int              m_cnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  dseg_xlate #(.VA_W(VA_W), .PA_W(PA_W), .CNT_W(CNT_W)) u_dseg_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .tlb_hit(tlb_hit), .tlb_pa(tlb_pa),
    .walk_req(walk_req), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_src(rsp_src), .rsp_miss(rsp_miss)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [VA_W-1:0] va);
    return (va >= m_start) && (va < m_end);
  endfunction

  // Driver: optional register write in the same cycle as the request
  task automatic issue(input logic [VA_W-1:0] va, input logic hit,
                       input logic [PA_W-1:0] pa, input bit with_wr,
                       input logic [1:0] wa, input logic [VA_W-1:0] wd);
    exp_t e;
    bit   seg;
    seg    = in_win(va);
    e.src  = seg;
    e.pa   = seg ? PA_W'(va - m_disp) : pa;
    e.miss = !seg && !hit;
    @(posedge clk); #1;
    req_valid = 1'b1; req_va = va; tlb_hit = hit; tlb_pa = pa;
    if (with_wr) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
    do @(negedge clk); while (!req_ready);
    chk(walk_req == e.miss, "R6", "walk_req", 64'(walk_req), 64'(e.miss));
    sb.push_back(e);
    if (seg && !hit && m_cnt < CMAX) m_cnt++;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (with_wr) begin
      cfg_we = 1'b0;
      case (wa)
        2'd0: m_start = wd;
        2'd1: m_end = wd;
        2'd2: m_disp = wd;
        default: m_cnt = 0;
      endcase
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R11", "rsp_valid after accept", 64'(rsp_valid), 64'd1);
  endtask

  task automatic cfg_write(input logic [1:0] wa, input logic [VA_W-1:0] wd);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (wa)
      2'd0: m_start = wd;
      2'd1: m_end = wd;
      2'd2: m_disp = wd;
      default: m_cnt = 0;
    endcase
  endtask

  task automatic cfg_check(input logic [1:0] wa, input logic [VA_W-1:0] exp,
                           input string req);
    @(posedge clk); #1;
    cfg_addr = wa;
    @(negedge clk);
    chk(cfg_rdata == exp, req, "cfg_rdata", 64'(cfg_rdata), 64'(exp));
  endtask

  // Monitor: compare each transferred response with the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2/R3", "unexpected response", 64'(rsp_pa), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_pa == e.pa, e.src ? "R2" : "R3", "rsp_pa", 64'(rsp_pa), 64'(e.pa));
          chk(rsp_src == e.src, "R2/R3 src", "rsp_src", 64'(rsp_src), 64'(e.src));
          chk(rsp_miss == e.miss, "R3/R6 miss", "rsp_miss", 64'(rsp_miss), 64'(e.miss));
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 4);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  localparam logic [VA_W-1:0] WS = 47'h10_0000_0000;
  localparam logic [VA_W-1:0] WE = 47'h20_0000_0000;
  localparam logic [VA_W-1:0] WD = 47'h0C_0000_0000;

  initial begin
    logic [PA_W-1:0] held;
    // R1: reset state
    #1;
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    for (int a = 0; a < 4; a++) cfg_check(2'(a), '0, "R1");

    // R5/R3: window off after reset, paging result passed through
    issue(47'h1000, 1'b1, 47'hABC000, 1'b0, 2'd0, '0);
    issue(47'h2000, 1'b0, 47'h5000, 1'b0, 2'd0, '0);

    // R8: program and read back
    cfg_write(2'd0, WS);
    cfg_write(2'd1, WE);
    cfg_write(2'd2, WD);
    cfg_check(2'd0, WS, "R8");
    cfg_check(2'd1, WE, "R8");
    cfg_check(2'd2, WD, "R8");

    // R2/R4: hits at both inclusive edges and in the middle
    issue(WS, 1'b0, 47'h1, 1'b0, 2'd0, '0);
    issue(WE - 1, 1'b0, 47'h2, 1'b0, 2'd0, '0);
    issue(47'h18_1234_5678, 1'b1, 47'h3, 1'b0, 2'd0, '0);
    // R4: exclusive end and just below start take paging
    issue(WE, 1'b0, 47'h7777, 1'b0, 2'd0, '0);
    issue(WS - 1, 1'b1, 47'h8888, 1'b0, 2'd0, '0);
    // R9: two counted hits so far
    cfg_check(2'd3, VA_W'(m_cnt), "R9");

    // R7: close the window in the same cycle as a request -> old values apply
    issue(WS + 5, 1'b0, 47'h9, 1'b1, 2'd1, WS);
    // R5: window now empty -> paging
    issue(WS + 5, 1'b0, 47'h99, 1'b0, 2'd0, '0);
    cfg_write(2'd1, WE);

    // R9: drive the counter into saturation
    for (int i = 0; i < 8; i++) issue(WS + 47'(i * 4096), 1'b0, '0, 1'b0, 2'd0, '0);
    cfg_check(2'd3, VA_W'(CMAX), "R9");
    issue(WS + 47'h40, 1'b1, '0, 1'b0, 2'd0, '0);
    cfg_check(2'd3, VA_W'(CMAX), "R9");
    cfg_write(2'd3, 47'h5);
    cfg_check(2'd3, '0, "R9");
    // R9: clear and increment together -> clear wins
    issue(WS + 47'h80, 1'b0, '0, 1'b1, 2'd3, '0);
    cfg_check(2'd3, '0, "R9");

    // R10: backpressure holds the response and blocks new requests
    @(posedge clk); #1 rsp_ready = 1'b0;
    issue(WS + 47'h100, 1'b0, '0, 1'b0, 2'd0, '0);
    held = rsp_pa;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R10", "rsp_valid held", 64'(rsp_valid), 64'd1);
      chk(rsp_pa == held, "R10", "rsp_pa held", 64'(rsp_pa), 64'(held));
      chk(req_ready == 1'b0, "R10", "req_ready stalled", 64'(req_ready), 64'd0);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready released", 64'(req_ready), 64'd1);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11", "scoreboard drained", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule